// File: doc/BRIEF.md
# HDLC Two-Byte Address Recognizer

This block sits behind the flag, destuffing and CRC stages of an HDLC receiver. It looks at the address field of each received frame and decides whether the frame is kept. In one-byte address mode the single address byte is compared against two programmable low-byte addresses. In two-byte address mode the first byte is compared against two programmable high-byte addresses and a fixed group address. The command/response bit is masked out of that comparison. The second byte is then compared against the low-byte addresses.

A kept frame is passed through whole, address bytes included. One status byte follows it, marked as the last byte. The status byte reports which high-byte candidate matched, the received command/response bit and which low-byte register matched. A frame that fails either comparison produces no output at all. So does a frame that ends before its address field is complete. Every output byte leaves three clock edges after the matching input byte. The status byte follows the frame's last byte on the very next cycle.

Top module: `hdlc_addr_filter`

## Requirements
- R1: In one-byte mode (`addr_mode`=0) the first byte of a frame is compared in full against `lo_addr_a` and `lo_addr_b`. On a hit the whole frame is forwarded, followed by a status byte.
- R2: In two-byte mode (`addr_mode`=1) the first byte is compared against `hi_addr_a`, `hi_addr_b` and the group value 8'hFC, with bit 1 ignored, so 8'hFE is also the group address. The frame is kept only if this byte hits and the second byte hits `lo_addr_a` or `lo_addr_b`.
- R3: The high-byte code HA is 2'b10 for a `hi_addr_a` hit, 2'b00 for a `hi_addr_b` hit and 2'b01 for a group hit. `hi_addr_a` takes precedence over `hi_addr_b`, and `hi_addr_b` over the group.
- R4: When `hi_addr_a` and `hi_addr_b` are equal apart from bit 1, a hit on that value reports 2'b10 and never 2'b00.
- R5: In two-byte mode the status C/R bit equals bit 1 of the received high address byte.
- R6: LA is 1 when the low byte equals `lo_addr_a` and 0 when it equals only `lo_addr_b`. A byte equal to both reports 1.
- R7: Status byte layout: HA in bits 7:6, C/R in bit 5, LA in bit 4, and bits 3:0 zero.
- R8: The status byte is output with `out_last`=1 on the cycle right after the frame's last byte. It is the only byte with `out_last`=1, and an output byte appears three clock edges after its input byte.
- R9: A frame whose high byte (two-byte mode) or low byte hits no candidate produces no output bytes and no status byte.
- R10: A frame that ends before its address field is complete produces no output.
- R11: Valid bytes that arrive outside a frame, that is without `in_sof` and with no frame open, are ignored.
- R12: In one-byte mode the status byte reports HA=2'b00 and C/R=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Received byte |
| in_sof | input | 1 | First byte of a frame |
| in_eof | input | 1 | Last byte of a frame |
| addr_mode | input | 1 | 0: one-byte address, 1: two-byte address |
| hi_addr_a | input | 8 | First high-byte address |
| hi_addr_b | input | 8 | Second high-byte address |
| lo_addr_a | input | 8 | First low-byte address |
| lo_addr_b | input | 8 | Second low-byte address |
| out_valid | output | 1 | Output byte valid |
| out_data | output | 8 | Forwarded byte or status byte |
| out_last | output | 1 | Marks the status byte closing a frame |

## Verification
The assertions rely on some rules about the inputs. At least one idle cycle must follow every byte that carries `in_eof`, so that a status byte never meets the first byte of the next frame. The mode and the four address registers must stay steady for the whole of a frame. The bench sends each frame as a burst of back-to-back bytes. It changes the registers and the mode only while the input is idle, and it waits several cycles between frames. Stray bytes without `in_sof` are injected only in those idle gaps.

// File: rtl/hdlc_addr_pkg.sv
package hdlc_addr_pkg;

    localparam int BYTE_W     = 8;
    localparam int ADDR_MAX   = 2;
    localparam logic [BYTE_W-1:0] CR_MASK  = 8'hFD;
    localparam logic [BYTE_W-1:0] GRP_ADDR = 8'hFC;

    typedef enum logic [1:0] {
        HA_SEC = 2'b00,
        HA_GRP = 2'b01,
        HA_PRI = 2'b10
    } ha_code_e;

    typedef struct packed {
        logic              vld;
        logic              sof;
        logic              eof;
        logic [BYTE_W-1:0] data;
    } beat_t;

    typedef struct packed {
        logic     keep;
        ha_code_e ha;
        logic     cr;
        logic     la;
    } verdict_t;

    typedef struct packed {
        logic     ok;
        ha_code_e ha;
    } hi_res_t;

    // High-byte comparison with the C/R bit masked; first register wins
    function automatic hi_res_t hi_eval(input logic [BYTE_W-1:0] b,
                                        input logic [BYTE_W-1:0] r1,
                                        input logic [BYTE_W-1:0] r2);
        hi_res_t r;
        logic [BYTE_W-1:0] m;
        m    = b & CR_MASK;
        r.ok = 1'b1;
        if (m == (r1 & CR_MASK))      r.ha = HA_PRI;
        else if (m == (r2 & CR_MASK)) r.ha = HA_SEC;
        else if (m == GRP_ADDR)       r.ha = HA_GRP;
        else begin
            r.ok = 1'b0;
            r.ha = HA_SEC;
        end
        return r;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_status(input verdict_t v);
        return {v.ha, v.cr, v.la, 4'b0000};
    endfunction

endpackage

// File: rtl/hdlc_addr_match.sv
module hdlc_addr_match
    import hdlc_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              mode_2b,
    input  logic [BYTE_W-1:0] hi_a,
    input  logic [BYTE_W-1:0] hi_b,
    input  logic [BYTE_W-1:0] lo_a,
    input  logic [BYTE_W-1:0] lo_b,
    output logic              in_frame,
    output verdict_t          verdict
);

    logic     frame_q;
    logic     mode_q;
    logic     hi_pend_q;
    logic     hi_ok_q;
    ha_code_e hi_ha_q;
    logic     cr_q;
    verdict_t verdict_q;

    hi_res_t  hi_res;
    logic     lo1_hit;
    logic     lo_hit;
    logic     accept_byte;

    assign hi_res      = hi_eval(in_data, hi_a, hi_b);
    assign lo1_hit     = (in_data == lo_a);
    assign lo_hit      = lo1_hit || (in_data == lo_b);
    assign accept_byte = in_valid && (in_sof || frame_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q   <= 1'b0;
            mode_q    <= 1'b0;
            hi_pend_q <= 1'b0;
            hi_ok_q   <= 1'b0;
            hi_ha_q   <= HA_SEC;
            cr_q      <= 1'b0;
            verdict_q <= '0;
        end else if (accept_byte) begin
            frame_q <= !in_eof;
            if (in_sof) begin
                mode_q <= mode_2b;
                if (mode_2b) begin
                    hi_pend_q      <= 1'b1;
                    hi_ok_q        <= hi_res.ok;
                    hi_ha_q        <= hi_res.ha;
                    cr_q           <= in_data[1];
                    verdict_q.keep <= 1'b0;
                end else begin
                    hi_pend_q <= 1'b0;
                    verdict_q <= '{keep: lo_hit, ha: HA_SEC, cr: 1'b0, la: lo1_hit};
                end
            end else begin
                hi_pend_q <= 1'b0;
                if (mode_q && hi_pend_q) begin
                    verdict_q <= '{keep: hi_ok_q && lo_hit, ha: hi_ha_q,
                                   cr: cr_q, la: lo1_hit};
                end
            end
        end
    end

    assign in_frame = frame_q;
    assign verdict  = verdict_q;

    AST_ONEBYTE_NO_HIGH: assert property (@(posedge clk) disable iff (rst)
        (verdict_q.keep && !mode_q) |-> (verdict_q.ha == HA_SEC && !verdict_q.cr)); // R12

    AST_EQUAL_HIGH_PRI: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && mode_2b && hi_res.ok &&
         ((hi_a & CR_MASK) == (hi_b & CR_MASK))) |-> (hi_res.ha != HA_SEC)); // R4

    AST_HIGH_PRIORITY: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_sof && mode_2b &&
         ((in_data & CR_MASK) == (hi_a & CR_MASK))) |=> (hi_ha_q == HA_PRI)); // R3

endmodule

// File: rtl/hdlc_beat_delay.sv
module hdlc_beat_delay
    import hdlc_addr_pkg::*;
#(
    parameter int DEPTH = ADDR_MAX
) (
    input  logic  clk,
    input  logic  rst,
    input  beat_t d,
    output beat_t q
);

    beat_t stage [DEPTH];

    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_stage
            if (g == 0) begin : g_head
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= d;
                end
            end else begin : g_tail
                always_ff @(posedge clk) begin
                    if (rst) stage[g] <= '0;
                    else     stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    assign q = stage[DEPTH-1];

endmodule

// File: rtl/hdlc_out_stage.sv
module hdlc_out_stage
    import hdlc_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  beat_t             beat,
    input  verdict_t          verdict,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last
);

    logic              pend_q;
    logic [BYTE_W-1:0] status_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q    <= 1'b0;
            status_q  <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (pend_q) begin
            pend_q    <= 1'b0;
            out_valid <= 1'b1;
            out_data  <= status_q;
            out_last  <= 1'b1;
        end else if (beat.vld && verdict.keep) begin
            out_valid <= 1'b1;
            out_data  <= beat.data;
            out_last  <= 1'b0;
            if (beat.eof) begin
                pend_q   <= 1'b1;
                status_q <= pack_status(verdict);
            end
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

    AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid); // R8

    AST_SINGLE_STATUS: assert property (@(posedge clk) disable iff (rst)
        out_last |=> !out_last); // R8

    AST_STATUS_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
        $rose(out_last) |-> $past(out_valid)); // R8

    AST_STATUS_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        out_last |-> (out_data[3:0] == 4'b0000)); // R7

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
    import hdlc_addr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_sof,
    input  logic              in_eof,
    input  logic              addr_mode,
    input  logic [BYTE_W-1:0] hi_addr_a,
    input  logic [BYTE_W-1:0] hi_addr_b,
    input  logic [BYTE_W-1:0] lo_addr_a,
    input  logic [BYTE_W-1:0] lo_addr_b,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last
);

    localparam int DELAY = ADDR_MAX;

    logic     in_frame;
    verdict_t verdict;
    beat_t    beat_in;
    beat_t    beat_out;

    hdlc_addr_match u_match (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_sof   (in_sof),
        .in_eof   (in_eof),
        .in_data  (in_data),
        .mode_2b  (addr_mode),
        .hi_a     (hi_addr_a),
        .hi_b     (hi_addr_b),
        .lo_a     (lo_addr_a),
        .lo_b     (lo_addr_b),
        .in_frame (in_frame),
        .verdict  (verdict)
    );

    always_comb begin
        beat_in.vld  = in_valid && (in_sof || in_frame);
        beat_in.sof  = in_sof;
        beat_in.eof  = in_eof;
        beat_in.data = in_data;
    end

    hdlc_beat_delay #(.DEPTH(DELAY)) u_delay (
        .clk (clk),
        .rst (rst),
        .d   (beat_in),
        .q   (beat_out)
    );

    hdlc_out_stage u_out (
        .clk       (clk),
        .rst       (rst),
        .beat      (beat_out),
        .verdict   (verdict),
        .out_valid (out_valid),
        .out_data  (out_data),
        .out_last  (out_last)
    );

    AST_STRAY_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !in_sof && !in_frame) |=> !u_delay.stage[0].vld); // R11

endmodule

// File: tb/hdlc_addr_filter_tb.sv
module hdlc_addr_filter_tb;

    typedef struct {
        logic [7:0] d;
        logic       l;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_sof = 1'b0;
    logic       in_eof = 1'b0;
    logic       addr_mode = 1'b0;
    logic [7:0] hi_addr_a = 8'h40;
    logic [7:0] hi_addr_b = 8'h60;
    logic [7:0] lo_addr_a = 8'h11;
    logic [7:0] lo_addr_b = 8'h22;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;

    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;
    bit    prev_valid = 0;
    bit    prev_last  = 0;
    string cur_tag  = "R8";
    exp_t  exp_q[$];
    logic [7:0] frm[$];

    always #4 clk = ~clk;

    hdlc_addr_filter u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
        .in_sof(in_sof), .in_eof(in_eof), .addr_mode(addr_mode),
        .hi_addr_a(hi_addr_a), .hi_addr_b(hi_addr_b),
        .lo_addr_a(lo_addr_a), .lo_addr_b(lo_addr_b),
        .out_valid(out_valid), .out_data(out_data), .out_last(out_last)
    );

    // Reference: compare every output cycle with the expected queue
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    n_checks++; n_fail++;
                    $display("FAIL %s unexpected output actual %h/%0b expected none",
                             cur_tag, out_data, out_last);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    n_checks++;
                    if (out_data !== e.d || out_last !== e.l) begin
                        n_fail++;
                        $display("FAIL %s actual %h/%0b expected %h/%0b",
                                 e.tag, out_data, out_last, e.d, e.l);
                    end
                    if (out_last) begin
                        // R8: status directly after the last frame byte
                        n_checks++;
                        if (!(prev_valid && !prev_last)) begin
                            n_fail++;
                            $display("FAIL R8 status gap actual prev_valid=%0b expected 1",
                                     prev_valid);
                        end
                    end
                end
            end
            prev_valid = out_valid;
            prev_last  = out_last;
        end
    end

    task automatic drive(input logic [7:0] d, input logic s, input logic e);
        @(negedge clk);
        in_valid = 1'b1; in_data = d; in_sof = s; in_eof = e;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
        end
    endtask

    // Behavioural model of the acceptance rules and the status byte
    task automatic model(input bit two, input string tag);
        int   need;
        logic [1:0] ha;
        logic cr, la;
        logic [7:0] lo, h;
        exp_t e;
        need = two ? 2 : 1;
        if (frm.size() < need) return;                         // R10
        if (two) begin
            h = frm[0] & 8'hFD;
            if (h == (hi_addr_a & 8'hFD))      ha = 2'b10;
            else if (h == (hi_addr_b & 8'hFD)) ha = 2'b00;
            else if (h == 8'hFC)               ha = 2'b01;
            else return;                                       // R9
            cr = frm[0][1];
            lo = frm[1];
        end else begin
            ha = 2'b00; cr = 1'b0; lo = frm[0];                // R12
        end
        if (lo == lo_addr_a)      la = 1'b1;
        else if (lo == lo_addr_b) la = 1'b0;
        else return;                                           // R9
        foreach (frm[i]) begin
            e.d = frm[i]; e.l = 1'b0; e.tag = tag;
            exp_q.push_back(e);
        end
        e.d = {ha, cr, la, 4'b0000}; e.l = 1'b1; e.tag = {tag, "/R7"};
        exp_q.push_back(e);
    endtask

    task automatic send(input bit two, input string tag);
        addr_mode = two;
        cur_tag = tag;
        model(two, tag);
        foreach (frm[i]) drive(frm[i], i == 0, i == frm.size() - 1);
        idle(6);
        n_checks++;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL %s missing outputs actual %0d left expected 0",
                     tag, exp_q.size());
            exp_q.delete();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        idle(3);
        @(negedge clk);
        n_checks++;
        if (out_valid !== 1'b0 || out_last !== 1'b0) begin
            n_fail++;
            $display("FAIL R8 reset state actual %0b/%0b expected 0/0", out_valid, out_last);
        end
        rst = 1'b0;
        idle(2);

        // One-byte mode
        frm = {8'h11, 8'hAA, 8'hBB};        send(0, "R1");
        frm = {8'h22, 8'h33};               send(0, "R6");
        frm = {8'h33, 8'h44, 8'h55};        send(0, "R9");
        frm = {8'h22};                      send(0, "R8");
        frm = {8'h11, 8'h42};               send(0, "R12");

        // Two-byte mode
        frm = {8'h40, 8'h11, 8'h5A};        send(1, "R3");
        frm = {8'h42, 8'h22, 8'h77};        send(1, "R5");
        frm = {8'h60, 8'h11};               send(1, "R3");
        frm = {8'h62, 8'h22, 8'h01};        send(1, "R5");
        frm = {8'hFE, 8'h22, 8'h01};        send(1, "R2");
        frm = {8'hFC, 8'h11};               send(1, "R2");
        frm = {8'h80, 8'h11, 8'h99};        send(1, "R9");
        frm = {8'h40, 8'h99, 8'h12};        send(1, "R9");
        frm = {8'h40};                      send(1, "R10");

        // R11: stray bytes without a frame start
        cur_tag = "R11";
        drive(8'h11, 1'b0, 1'b0);
        drive(8'h40, 1'b0, 1'b1);
        idle(6);
        frm = {8'h40, 8'h11, 8'h01};        send(1, "R11");

        // R6 priority: both low registers equal
        lo_addr_b = 8'h11;
        idle(1);
        frm = {8'h11, 8'h66};               send(0, "R6");
        lo_addr_b = 8'h22;

        // R4: equal high registers
        hi_addr_b = 8'h42;
        idle(1);
        frm = {8'h40, 8'h11};               send(1, "R4");
        frm = {8'h42, 8'h22, 8'h0F};        send(1, "R4");

        // R3: first register equal to the group value
        hi_addr_a = 8'hFC;
        idle(1);
        frm = {8'hFE, 8'h11};               send(1, "R3");

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule